// File: doc/BRIEF.md
# SPI Boot Handshake Host Engine

This block is a hardware SPI master that brings up the boot-time link to a processor whose boot loader waits as an SPI slave. After a single start strobe it runs three phases on its own. The first is start-word synchronisation, with retries. The second is a ping exchange carrying a 32-bit count. The third sends one command word. In each phase it checks every reply word the slave shifts back. The user reads the outcome from a done flag, an error flag, a stage code and the last 16-bit word received.

Every transfer is a 16-bit frame framed by its own active-low chip select, so only clock, MOSI, MISO and chip select are used. The slave answers a frame during the frame that follows it, so each exchange ends with a dummy 0x0000 frame that clocks the final reply out. A 32-bit quantity goes out as two frames, the low halfword first.

The SCLK half period (`clk_div`) and the idle gap before each frame (`gap_cycles`) are given in system clock cycles and can be changed at run time. With a 100 MHz system clock, the values 50 and 1000 give about 1 MHz and about 10 µs.

Top module: `bootsync_host`

## Requirements
- R1: Every frame holds `spi_cs_n` low for exactly 16 rising SCLK edges. SCLK idles low whenever `spi_cs_n` is high.
- R2: SPI mode 0, MSB first. MOSI changes only while SCLK is low, and MISO is captured on each rising SCLK edge.
- R3: Synchronisation sends 0x5853 and then 0x0000. The word captured during the 0x0000 frame must be 0x5253; any other value, 0xFFFF included, is a failed attempt.
- R4: After a failed attempt the synchronisation pair is sent again, up to `retry_limit` further times. Once the limit is used up, `err` rises, `stage` stays at 1 and no further frame is sent.
- R5: The ping phase sends 0x590B, 0x5853, count[15:0], count[31:16] and 0x0000, in that order. The replies on the second through fifth of these frames must be 0x590B, 0x5253, count[15:0] and count[31:16].
- R6: The command phase sends the `cmd_op` value latched at start, then 0x5853, then 0x0000. The replies on the second and third frames must be the latched `cmd_op` and 0x5253. On success `done` rises and `stage` becomes 4.
- R7: A reply mismatch in the ping or command phase raises `err` at once. `stage` keeps the failing phase, with ping = 2 and command = 3, and the link stays idle.
- R8: `last_rx` holds the word captured in the most recent completed frame.
- R9: Each SCLK high phase lasts exactly `clk_div` system cycles. Before every frame, `spi_cs_n` stays high for at least `gap_cycles` system cycles.
- R10: A start while a run is in progress is ignored, and the inputs latched for that run are kept. A start while idle clears `done` and `err` and sets `stage` to 1.
- R11: After reset, `spi_cs_n` = 1, `spi_sclk` = 0, `done` = 0, `err` = 0 and `stage` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a handshake run when idle |
| cmd_op | input | 16 | Low halfword of the command (high half is fixed 0x5853) |
| ping_count | input | 32 | Count value sent after the ping command |
| clk_div | input | DIV_W | SCLK half period in system cycles |
| gap_cycles | input | GAP_W | Minimum chip-select idle time before each frame |
| retry_limit | input | RETRY_W | Extra synchronisation attempts allowed |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |
| spi_cs_n | output | 1 | Active-low chip select |
| done | output | 1 | Run finished successfully |
| err | output | 1 | Run aborted on a reply mismatch |
| stage | output | 3 | 0 idle, 1 sync, 2 ping, 3 command, 4 done |
| last_rx | output | 16 | Last received frame |

## Verification
The hardest case to reach is the boundary of the retry budget. The slave has to fail exactly as many synchronisation attempts as the limit allows, so that the last allowed retry succeeds, and then fail one more time than that in a second run, so that the error is raised. The bench slave is a behavioural echo model. It answers 0x5853 with 0x5253, echoes every other word, and can be told to answer the first N synchronisation words with 0xFFFF or to corrupt the echo of one chosen word. That lets a mismatch be placed in a single chosen frame of any phase, and the frame log on MOSI then shows exactly where the sequencer stopped.

// File: rtl/bootsync_pkg.sv
package bootsync_pkg;
  localparam int unsigned FRAME_W = 16;

  localparam logic [15:0] W_SYNC   = 16'h5853;
  localparam logic [15:0] W_ACK    = 16'h5253;
  localparam logic [15:0] W_PING   = 16'h590B;
  localparam logic [15:0] W_DUMMY  = 16'h0000;

  typedef enum logic [2:0] {
    STG_IDLE = 3'd0,
    STG_SYNC = 3'd1,
    STG_PING = 3'd2,
    STG_CMD  = 3'd3,
    STG_DONE = 3'd4
  } stage_t;

  typedef struct packed {
    logic [15:0] tx;    // word to shift out
    logic [15:0] exp;   // reply expected during this frame
    logic        chk;   // reply is checked
    logic        last;  // final frame of the phase
  } frame_plan_t;

  function automatic frame_plan_t plan_frame(stage_t s, logic [2:0] idx,
                                             logic [15:0] op, logic [31:0] cnt);
    frame_plan_t p;
    p = '{tx: W_DUMMY, exp: W_DUMMY, chk: 1'b0, last: 1'b0};
    case (s)
      STG_SYNC: begin
        if (idx == 3'd0) p.tx = W_SYNC;
        else begin p.exp = W_ACK; p.chk = 1'b1; p.last = 1'b1; end
      end
      STG_PING: begin
        case (idx)
          3'd0: p.tx = W_PING;
          3'd1: begin p.tx = W_SYNC;     p.exp = W_PING;     p.chk = 1'b1; end
          3'd2: begin p.tx = cnt[15:0];  p.exp = W_ACK;      p.chk = 1'b1; end
          3'd3: begin p.tx = cnt[31:16]; p.exp = cnt[15:0];  p.chk = 1'b1; end
          default: begin p.exp = cnt[31:16]; p.chk = 1'b1; p.last = 1'b1; end
        endcase
      end
      STG_CMD: begin
        case (idx)
          3'd0: p.tx = op;
          3'd1: begin p.tx = W_SYNC; p.exp = op; p.chk = 1'b1; end
          default: begin p.exp = W_ACK; p.chk = 1'b1; p.last = 1'b1; end
        endcase
      end
      default: p.tx = W_DUMMY;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bs_miso_sync.sv
module bs_miso_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES == 0) begin : g_direct
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      for (genvar i = 0; i < STAGES; i++) begin : g_ff
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else if (i == 0) chain[i] <= din;
          else chain[i] <= chain[(i == 0) ? 0 : i-1];
        end
      end
      assign dout = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bs_frame_engine.sv
module bs_frame_engine #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned GAP_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [FRAME_W-1:0] tx,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic [GAP_W-1:0]   gap_cycles,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               fdone,
  output logic [FRAME_W-1:0] rx
);
  localparam int unsigned CNT_W = (DIV_W > GAP_W) ? DIV_W : GAP_W;
  localparam int unsigned BIT_W = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {E_IDLE, E_GAP, E_LOW, E_HIGH} eng_t;

  eng_t               st;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   nbits;
  logic [FRAME_W-1:0] tx_sh;
  logic               half_done;
  logic               gap_done;

  assign half_done = ({1'b0, cnt} + 1'b1) >= (CNT_W+1)'(clk_div);
  assign gap_done  = cnt >= CNT_W'(gap_cycles);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= E_IDLE;
      cnt   <= '0;
      nbits <= '0;
      tx_sh <= '0;
      rx    <= '0;
      sclk  <= 1'b0;
      mosi  <= 1'b0;
      cs_n  <= 1'b1;
      fdone <= 1'b0;
    end else begin
      fdone <= 1'b0;
      case (st)
        E_IDLE: if (go) begin
          tx_sh <= tx;
          cnt   <= '0;
          st    <= E_GAP;
        end
        E_GAP: begin
          if (gap_done) begin
            cs_n  <= 1'b0;
            mosi  <= tx_sh[FRAME_W-1];
            nbits <= '0;
            cnt   <= '0;
            st    <= E_LOW;
          end else cnt <= cnt + 1'b1;
        end
        E_LOW: begin
          if (half_done) begin
            sclk  <= 1'b1;
            rx    <= {rx[FRAME_W-2:0], miso};
            nbits <= nbits + 1'b1;
            cnt   <= '0;
            st    <= E_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        E_HIGH: begin
          if (half_done) begin
            sclk <= 1'b0;
            cnt  <= '0;
            if (nbits == BIT_W'(FRAME_W)) begin
              cs_n  <= 1'b1;
              mosi  <= 1'b0;
              fdone <= 1'b1;
              st    <= E_IDLE;
            end else begin
              tx_sh <= tx_sh << 1;
              mosi  <= tx_sh[FRAME_W-2];
              st    <= E_LOW;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bs_seq.sv
module bs_seq
  import bootsync_pkg::*;
#(
  parameter int unsigned RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [15:0]        cmd_op,
  input  logic [31:0]        ping_count,
  input  logic [RETRY_W-1:0] retry_limit,
  input  logic               fr_done,
  input  logic [15:0]        fr_rx,
  output logic               fr_go,
  output logic [15:0]        fr_tx,
  output logic               done,
  output logic               err,
  output logic [2:0]         stage,
  output logic [15:0]        last_rx
);
  stage_t             stage_q;
  logic [2:0]         idx_q;
  logic [RETRY_W-1:0] tries_q;
  logic [15:0]        op_q;
  logic [31:0]        cnt_q;
  logic               active_q;
  logic               go_q;
  frame_plan_t        cur;

  assign cur   = plan_frame(stage_q, idx_q, op_q, cnt_q);
  assign fr_tx = cur.tx;
  assign fr_go = go_q;
  assign stage = stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= STG_IDLE;
      idx_q    <= '0;
      tries_q  <= '0;
      op_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      go_q     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      last_rx  <= '0;
    end else begin
      go_q <= 1'b0;
      if (start && !active_q) begin
        op_q     <= cmd_op;
        cnt_q    <= ping_count;
        stage_q  <= STG_SYNC;
        idx_q    <= '0;
        tries_q  <= '0;
        done     <= 1'b0;
        err      <= 1'b0;
        active_q <= 1'b1;
        go_q     <= 1'b1;
      end else if (active_q && fr_done) begin
        last_rx <= fr_rx;
        if (cur.chk && (fr_rx != cur.exp)) begin
          if ((stage_q == STG_SYNC) && (tries_q < retry_limit)) begin
            tries_q <= tries_q + 1'b1;
            idx_q   <= '0;
            go_q    <= 1'b1;
          end else begin
            err      <= 1'b1;
            active_q <= 1'b0;
          end
        end else if (cur.last) begin
          if (stage_q == STG_CMD) begin
            done     <= 1'b1;
            stage_q  <= STG_DONE;
            active_q <= 1'b0;
          end else begin
            stage_q <= (stage_q == STG_SYNC) ? STG_PING : STG_CMD;
            idx_q   <= '0;
            go_q    <= 1'b1;
          end
        end else begin
          idx_q <= idx_q + 1'b1;
          go_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bootsync_host.sv
module bootsync_host
  import bootsync_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned GAP_W     = 12,
  parameter int unsigned RETRY_W   = 8,
  parameter int unsigned MISO_SYNC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [15:0]        cmd_op,
  input  logic [31:0]        ping_count,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic [GAP_W-1:0]   gap_cycles,
  input  logic [RETRY_W-1:0] retry_limit,
  output logic               spi_sclk,
  output logic               spi_mosi,
  input  logic               spi_miso,
  output logic               spi_cs_n,
  output logic               done,
  output logic               err,
  output logic [2:0]         stage,
  output logic [15:0]        last_rx
);
  logic                miso_s;
  logic                fr_go;
  logic                fr_done;
  logic [FRAME_W-1:0]  fr_tx;
  logic [FRAME_W-1:0]  fr_rx;

  bs_miso_sync #(.STAGES(MISO_SYNC)) u_sync (
    .clk(clk), .rst(rst), .din(spi_miso), .dout(miso_s)
  );

  bs_frame_engine #(.FRAME_W(FRAME_W), .DIV_W(DIV_W), .GAP_W(GAP_W)) u_eng (
    .clk(clk), .rst(rst), .go(fr_go), .tx(fr_tx),
    .clk_div(clk_div), .gap_cycles(gap_cycles), .miso(miso_s),
    .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .fdone(fr_done), .rx(fr_rx)
  );

  bs_seq #(.RETRY_W(RETRY_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cmd_op(cmd_op),
    .ping_count(ping_count), .retry_limit(retry_limit),
    .fr_done(fr_done), .fr_rx(fr_rx), .fr_go(fr_go), .fr_tx(fr_tx),
    .done(done), .err(err), .stage(stage), .last_rx(last_rx)
  );
endmodule

// File: rtl/bootsync_host_chk.sv
module bootsync_host_chk #(
  parameter int unsigned GAP_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             spi_sclk,
  input logic             spi_mosi,
  input logic             spi_cs_n,
  input logic             done,
  input logic             err,
  input logic [2:0]       stage,
  input logic [GAP_W-1:0] gap_cycles
);
  logic [GAP_W:0] hi_cnt;
  logic [5:0]     edge_cnt;
  logic           sclk_d;
  logic           idle_now;

  assign idle_now = done || err || (stage == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      edge_cnt <= '0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= spi_sclk;
      if (!spi_cs_n) hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      if (spi_cs_n) edge_cnt <= '0;
      else if (spi_sclk && !sclk_d) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  // R1: clock idles low outside a frame
  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  // R1: 16 rising edges per frame
  p_frame_edges_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> (edge_cnt == 6'd16));

  // R2: MOSI moves only while SCLK is low
  p_mosi_low_r2: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && !$stable(spi_mosi)) |-> !spi_sclk);

  // R9: chip-select gap before a frame
  p_cs_gap_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (hi_cnt >= {1'b0, gap_cycles}));

  // R7: flags exclusive and link quiet on error
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> spi_cs_n);

  // R10: start from idle clears flags and enters sync
  p_start_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (start && idle_now) |=> (!done && !err && stage == 3'd1));
endmodule

bind bootsync_host bootsync_host_chk #(.GAP_W(GAP_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .done(done), .err(err),
  .stage(stage), .gap_cycles(gap_cycles)
);

// File: tb/sim_bootsync_host.sv
`timescale 1ns/1ps
module sim_bootsync_host;
  localparam int DIV = 4;
  localparam int GAP = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] cmd_op = 16'h590D;
  logic [31:0] ping_count = 32'h0000_0001;
  logic [7:0]  clk_div = 8'(DIV);
  logic [11:0] gap_cycles = 12'(GAP);
  logic [7:0]  retry_limit = 8'd3;
  logic        spi_sclk, spi_mosi, spi_cs_n, done, err;
  logic        spi_miso = 1'b1;
  logic [2:0]  stage;
  logic [15:0] last_rx;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  bootsync_host u0 (
    .clk(clk), .rst(rst), .start(start), .cmd_op(cmd_op),
    .ping_count(ping_count), .clk_div(clk_div), .gap_cycles(gap_cycles),
    .retry_limit(retry_limit), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .done(done), .err(err),
    .stage(stage), .last_rx(last_rx)
  );

  // ---------------- behavioural slave ----------------
  logic [15:0] s_rx, s_tx, s_reply;
  int          s_bits;
  int          fail_left = 0;
  logic        corrupt_en = 1'b0;
  logic [15:0] corrupt_word = 16'h0;
  logic [15:0] mlog [0:63];
  int          nlog = 0;
  int          bad_bits = 0;

  initial s_reply = 16'hFFFF;

  always @(negedge spi_cs_n) begin
    s_bits = 0;
    s_tx = s_reply;
    spi_miso = s_tx[15];
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    s_rx = {s_rx[14:0], spi_mosi};
    s_bits = s_bits + 1;
  end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    s_tx = s_tx << 1;
    spi_miso = s_tx[15];
  end
  always @(posedge spi_cs_n) if (!rst) begin
    if (s_bits != 16) bad_bits = bad_bits + 1;
    if (nlog < 64) mlog[nlog] = s_rx;
    nlog = nlog + 1;
    if (s_rx == 16'h5853) begin
      if (fail_left > 0) begin s_reply = 16'hFFFF; fail_left = fail_left - 1; end
      else s_reply = 16'h5253;
    end else if (corrupt_en && s_rx == corrupt_word) s_reply = s_rx ^ 16'h0001;
    else s_reply = s_rx;
    spi_miso = 1'b1;
  end

  // ---------------- timing monitor (R9) ----------------
  int hi_len = 0, cs_len = 0, bad_half = 0, bad_gap = 0;
  logic sclk_p = 1'b0, cs_p = 1'b1;
  always @(negedge clk) if (!rst) begin
    if (spi_sclk) hi_len = hi_len + 1;
    else if (sclk_p) begin
      if (hi_len != DIV) bad_half = bad_half + 1;
      hi_len = 0;
    end
    if (spi_cs_n) cs_len = cs_len + 1;
    else if (cs_p) begin
      if (cs_len < GAP) bad_gap = bad_gap + 1;
      cs_len = 0;
    end
    sclk_p = spi_sclk;
    cs_p = spi_cs_n;
  end

  // ---------------- helpers ----------------
  logic [15:0] ex [0:63];
  int          nex;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    ex[nex] = w;
    nex++;
  endtask

  task automatic push_sync();  push(16'h5853); push(16'h0000); endtask
  task automatic push_ping(input logic [31:0] c);
    push(16'h590B); push(16'h5853); push(c[15:0]); push(c[31:16]); push(16'h0000);
  endtask
  task automatic push_cmd(input logic [15:0] op);
    push(op); push(16'h5853); push(16'h0000);
  endtask

  task automatic check_log(input string req);
    chk(nlog == nex, req, "frame count", 32'(nlog), 32'(nex));
    for (int i = 0; i < nex && i < nlog; i++)
      chk(mlog[i] == ex[i], req, $sformatf("mosi frame %0d", i), 32'(mlog[i]), 32'(ex[i]));
  endtask

  task automatic launch();
    nlog = 0; nex = 0; s_reply = 16'hFFFF;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!done && !err && n < 20000) begin @(negedge clk); n++; end
    repeat (5) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(spi_cs_n == 1'b1, "R11", "cs_n", 32'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0, "R11", "sclk", 32'(spi_sclk), 0);
    chk(done == 1'b0 && err == 1'b0, "R11", "flags", {done, err}, 0);
    chk(stage == 3'd0, "R11", "stage", 32'(stage), 0);
  endtask

  task automatic t_clean();
    fail_left = 0; corrupt_en = 0; retry_limit = 8'd3;
    cmd_op = 16'h590D; ping_count = 32'h0000_0001;
    launch();
    wait_end();
    push_sync(); push_ping(32'h0000_0001); push_cmd(16'h590D);
    check_log("R3 R5 R6 R2");
    chk(done == 1'b1 && err == 1'b0, "R6", "done/err", {done, err}, 2);
    chk(stage == 3'd4, "R6", "stage", 32'(stage), 4);
    chk(last_rx == 16'h5253, "R8", "last_rx", 32'(last_rx), 32'h5253);
  endtask

  task automatic t_retry_ok();
    fail_left = 3; corrupt_en = 0; retry_limit = 8'd3;
    ping_count = 32'h00A0_0003;
    launch();
    wait_end();
    for (int i = 0; i < 4; i++) push_sync();
    push_ping(32'h00A0_0003); push_cmd(16'h590D);
    check_log("R4 retry at limit");
    chk(done == 1'b1 && err == 1'b0, "R4", "done after last retry", {done, err}, 2);
  endtask

  task automatic t_retry_exhaust();
    fail_left = 10; corrupt_en = 0; retry_limit = 8'd2;
    launch();
    wait_end();
    for (int i = 0; i < 3; i++) push_sync();
    check_log("R4 exhaust");
    chk(err == 1'b1 && done == 1'b0, "R4", "err flag", {done, err}, 1);
    chk(stage == 3'd1, "R4", "stage", 32'(stage), 1);
    chk(last_rx == 16'hFFFF, "R3", "no-response word", 32'(last_rx), 32'hFFFF);
    repeat (200) @(negedge clk);
    chk(nlog == 6, "R4", "no frames after error", 32'(nlog), 6);
  endtask

  task automatic t_ping_bad();
    fail_left = 0; corrupt_en = 1; corrupt_word = 16'h0001; retry_limit = 8'd1;
    ping_count = 32'h0000_0001;
    launch();
    wait_end();
    push_sync(); push(16'h590B); push(16'h5853); push(16'h0001); push(16'h0000);
    check_log("R7 ping");
    chk(err == 1'b1, "R7", "ping err", 32'(err), 1);
    chk(stage == 3'd2, "R7", "ping stage", 32'(stage), 2);
    chk(last_rx == 16'h0000, "R8", "last_rx ping", 32'(last_rx), 0);
    corrupt_en = 0;
  endtask

  task automatic t_cmd_bad();
    fail_left = 0; corrupt_en = 1; corrupt_word = 16'h590D; retry_limit = 8'd1;
    ping_count = 32'h0002_0005; cmd_op = 16'h590D;
    launch();
    wait_end();
    push_sync(); push_ping(32'h0002_0005); push(16'h590D); push(16'h5853);
    check_log("R7 cmd");
    chk(err == 1'b1 && done == 1'b0, "R7", "cmd err", {done, err}, 1);
    chk(stage == 3'd3, "R7", "cmd stage", 32'(stage), 3);
    chk(last_rx == 16'h590C, "R8", "last_rx cmd", 32'(last_rx), 32'h590C);
    corrupt_en = 0;
  endtask

  task automatic t_busy_start();
    fail_left = 0; corrupt_en = 0; retry_limit = 8'd1;
    cmd_op = 16'h590D; ping_count = 32'h0000_0001;
    launch();
    repeat (2) @(negedge clk);
    chk(err == 1'b0 && stage == 3'd1, "R10", "start clears err", {err, stage}, 1);
    repeat (300) @(negedge clk);
    cmd_op = 16'h1234; ping_count = 32'h0000_0007;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end();
    push_sync(); push_ping(32'h0000_0001); push_cmd(16'h590D);
    check_log("R10 busy start");
    chk(done == 1'b1, "R10", "done", 32'(done), 1);
    chk(bad_half == 0, "R9", "sclk high length errors", 32'(bad_half), 0);
    chk(bad_gap == 0, "R9", "cs gap errors", 32'(bad_gap), 0);
    chk(bad_bits == 0, "R1", "frames not 16 bits", 32'(bad_bits), 0);
  endtask

  // ---------------- run ----------------
  bit finished = 0;
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_retry_ok();
    t_retry_exhaust();
    t_ping_bad();
    t_cmd_bad();
    t_busy_start();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule